// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block classifies each processor access to the first megabyte of the address space. It returns one of three targets: main RAM with full access, RAM that can only be read, or the PCI bus. Seven byte-wide attribute registers hold 2-bit fields, two per byte. One field covers the 64 KB system BIOS segment at 0xF0000. Twelve further fields cover 16 KB expansion-ROM segments starting at 0xC0000. A separate control byte, combined with a system-management-mode input, decides whether the 128 KB window at 0xA0000 is served by RAM or by PCI.

Configuration bytes are written through a simple byte port: an enable, an 8-bit offset and a data byte. A write takes effect on the clock edge that samples it. The target choice is combinational from the access address, the stored registers and the mode input, so it follows a mode change in the same cycle. A write to a read-only region is flagged as dropped, so that the memory side can discard it.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset, every attribute field is 0 and the window control byte is 0x02. Every access in 0xA0000–0xFFFFF therefore selects PCI (`tgt_sel` = 2), whatever the state of `smm_active`.
- R2: Accesses in 0xF0000–0xFFFFF use bits [5:4] of the byte at offset 0x59.
- R3: Segment i (0..11) covers 0xC0000 + 0x4000·i up to, but not including, 0xC0000 + 0x4000·(i+1). It uses the byte at offset 0x5A + i/2: bits [1:0] when i is even, bits [5:4] when i is odd.
- R4: The attribute value selects the target. Value 3 gives `tgt_sel` = 0 (RAM, read and write). Value 1 gives `tgt_sel` = 1 (RAM, read-only). Values 0 and 2 give `tgt_sel` = 2 (PCI).
- R5: `wr_drop` is 1 exactly when `acc_valid` and `acc_write` are both 1 and `tgt_sel` = 1. It is 0 for reads, for idle cycles and for every other target.
- R6: Accesses in 0xA0000–0xBFFFF select RAM (`tgt_sel` = 0) when (`smm_active` and bit 3 of the byte at offset 0x72) or bit 6 of that byte is 1. Otherwise they select PCI (`tgt_sel` = 2).
- R7: A change of `smm_active` changes the window decision in the same cycle, with no clock edge in between.
- R8: Any address below 0xA0000, or with a nonzero bit at position 20 or above, selects RAM (`tgt_sel` = 0).
- R9: A configuration write changes decoding from the cycle after the clock edge that samples it, not before. Writes to offsets other than 0x59–0x5F and 0x72 change no decision.
- R10: Bits [3:2] and [7:6] of the attribute bytes have no effect, and neither do bits [1:0] of offset 0x59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_off | input | 8 | Configuration byte offset |
| cfg_wr_data | input | 8 | Configuration byte value |
| smm_active | input | 1 | System-management mode indication |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access byte address |
| tgt_sel | output | 2 | 0 RAM, 1 read-only RAM, 2 PCI |
| wr_drop | output | 1 | Write to a read-only region is discarded |

## Verification
The assertions assume that configuration writes arrive only as single-cycle strobes. They also assume that `smm_active` and the access address change only between clock edges, so a stable-input property may claim a stable target whenever no write was sampled. The stimulus drives every input on the falling edge and pulses `cfg_wr_en` for one cycle only. It mixes random attribute bytes, including bits that must be ignored, with writes to neighbouring offsets that must be ignored. Addresses are biased into the legacy range, with some above 1 MB.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

   typedef enum logic [1:0] {
      TGT_RAM    = 2'd0,
      TGT_RAM_RO = 2'd1,
      TGT_PCI    = 2'd2
   } tgt_e;

   typedef enum logic [1:0] {
      RG_PASS = 2'd0,
      RG_WIN  = 2'd1,
      RG_FSEG = 2'd2,
      RG_XSEG = 2'd3
   } region_e;

   localparam int WIN_SMM_BIT  = 3;
   localparam int WIN_OPEN_BIT = 6;

   function automatic tgt_e attr_to_tgt(input logic [1:0] a);
      case (a)
         2'd3:    return TGT_RAM;
         2'd1:    return TGT_RAM_RO;
         default: return TGT_PCI;
      endcase
   endfunction

endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs #(
   parameter int         OFF_W      = 8,
   parameter int         ATTR_BASE  = 'h59,
   parameter int         ATTR_BYTES = 7,
   parameter int         WIN_OFF    = 'h72,
   parameter logic [7:0] WIN_RST    = 8'h02,
   localparam int        NUM_FIELDS = 2 * ATTR_BYTES
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [OFF_W-1:0]        wr_off,
   input  logic [7:0]              wr_data,
   output logic [2*NUM_FIELDS-1:0] fields,
   output logic                    win_smm_en,
   output logic                    win_open
);
   import lmd_pkg::*;

   logic unused_data_bits;
   assign unused_data_bits = ^{wr_data[7], wr_data[3:2]};

   // Field 0 (low nibble of the first byte) carries no region.
   assign fields[1:0] = 2'b00;

   for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_byte
      logic hit;
      assign hit = wr_en && (wr_off == OFF_W'(ATTR_BASE + b));

      if (b > 0) begin : g_lo
         logic [1:0] lo_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   lo_q <= 2'b00;
            else if (hit) lo_q <= wr_data[1:0];
         end
         assign fields[4*b +: 2] = lo_q;
      end

      logic [1:0] hi_q;
      always_ff @(posedge clk) begin
         if (!rst_n)   hi_q <= 2'b00;
         else if (hit) hi_q <= wr_data[5:4];
      end
      assign fields[4*b+2 +: 2] = hi_q;
   end

   logic win_hit;
   assign win_hit = wr_en && (wr_off == OFF_W'(WIN_OFF));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_smm_en <= WIN_RST[WIN_SMM_BIT];
         win_open   <= WIN_RST[WIN_OPEN_BIT];
      end else if (win_hit) begin
         win_smm_en <= wr_data[WIN_SMM_BIT];
         win_open   <= wr_data[WIN_OPEN_BIT];
      end
   end

endmodule

// File: rtl/lmd_addr_decode.sv
module lmd_addr_decode #(
   parameter int  ADDR_W     = 32,
   parameter int  NUM_SEGS   = 12,
   parameter int  SEG_SHIFT  = 14,
   localparam int SEG_IDX_W  = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
   input  logic [ADDR_W-1:0]    addr,
   output lmd_pkg::region_e     region,
   output logic [SEG_IDX_W-1:0] seg_idx
);
   import lmd_pkg::*;

   localparam logic [31:0] WIN_BASE  = 32'h000A_0000;
   localparam logic [31:0] WIN_END   = 32'h000C_0000;
   localparam logic [31:0] SEG_BASE  = 32'h000C_0000;
   localparam logic [31:0] SEG_END   = SEG_BASE + (32'(NUM_SEGS) << SEG_SHIFT);
   localparam logic [31:0] FSEG_BASE = 32'h000F_0000;

   logic        above_1m;
   logic [31:0] lo32;
   logic [31:0] seg_off;
   logic [31:0] seg_num;

   if (ADDR_W > 20) begin : g_wide
      assign above_1m = |addr[ADDR_W-1:20];
   end else begin : g_flat
      assign above_1m = 1'b0;
   end

   assign lo32    = {12'd0, addr[19:0]};
   assign seg_off = lo32 - SEG_BASE;
   assign seg_num = seg_off >> SEG_SHIFT;
   assign seg_idx = seg_num[SEG_IDX_W-1:0];

   logic unused_seg_bits;
   assign unused_seg_bits = ^seg_num[31:SEG_IDX_W];

   always_comb begin
      if (above_1m)                                 region = RG_PASS;
      else if (lo32 >= WIN_BASE && lo32 < WIN_END)  region = RG_WIN;
      else if (lo32 >= FSEG_BASE)                   region = RG_FSEG;
      else if (lo32 >= SEG_BASE && lo32 < SEG_END)  region = RG_XSEG;
      else                                          region = RG_PASS;
   end

endmodule

// File: rtl/lmd_target_sel.sv
module lmd_target_sel #(
   parameter int  NUM_FIELDS = 14,
   parameter int  NUM_SEGS   = 12,
   localparam int SEG_IDX_W  = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
   localparam int FSEG_FIELD = 1,
   localparam int SEG_FIELD0 = 2
) (
   input  logic [2*NUM_FIELDS-1:0] fields,
   input  lmd_pkg::region_e        region,
   input  logic [SEG_IDX_W-1:0]    seg_idx,
   input  logic                    smm_active,
   input  logic                    win_smm_en,
   input  logic                    win_open,
   output lmd_pkg::tgt_e           tgt
);
   import lmd_pkg::*;

   logic       win_ram;
   logic [1:0] seg_attr;

   assign win_ram  = (smm_active && win_smm_en) || win_open;
   assign seg_attr = fields[2*(SEG_FIELD0 + int'(seg_idx)) +: 2];

   always_comb begin
      case (region)
         RG_WIN:  tgt = win_ram ? TGT_RAM : TGT_PCI;
         RG_FSEG: tgt = attr_to_tgt(fields[2*FSEG_FIELD +: 2]);
         RG_XSEG: tgt = attr_to_tgt(seg_attr);
         default: tgt = TGT_RAM;
      endcase
   end

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder #(
   parameter int         OFF_W      = 8,
   parameter int         ADDR_W     = 32,
   parameter int         ATTR_BASE  = 'h59,
   parameter int         ATTR_BYTES = 7,
   parameter int         NUM_SEGS   = 12,
   parameter int         SEG_SHIFT  = 14,
   parameter int         SMRAM_OFF  = 'h72,
   parameter logic [7:0] SMRAM_RST  = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [OFF_W-1:0]  cfg_wr_off,
   input  logic [7:0]        cfg_wr_data,
   input  logic              smm_active,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [1:0]        tgt_sel,
   output logic              wr_drop
);
   import lmd_pkg::*;

   localparam int NUM_FIELDS = 2 * ATTR_BYTES;
   localparam int SEG_IDX_W  = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;

   if (ADDR_W < 20) begin : g_bad_addr
      $error("ADDR_W must cover the first megabyte");
   end
   if (NUM_SEGS + 2 > NUM_FIELDS) begin : g_bad_fields
      $error("not enough attribute fields for the segments");
   end
   if ((32'h000C_0000 + (NUM_SEGS << SEG_SHIFT)) > 32'h000F_0000) begin : g_bad_span
      $error("expansion segments overlap the BIOS segment");
   end
   if (OFF_W < 8 && (SMRAM_OFF >= (1 << OFF_W))) begin : g_bad_off
      $error("offset width too small for window control byte");
   end

   logic [2*NUM_FIELDS-1:0] fields;
   logic                    win_smm_en;
   logic                    win_open;
   region_e                 region;
   logic [SEG_IDX_W-1:0]    seg_idx;
   tgt_e                    tgt;

   lmd_cfg_regs #(
      .OFF_W      (OFF_W),
      .ATTR_BASE  (ATTR_BASE),
      .ATTR_BYTES (ATTR_BYTES),
      .WIN_OFF    (SMRAM_OFF),
      .WIN_RST    (SMRAM_RST)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr_en),
      .wr_off     (cfg_wr_off),
      .wr_data    (cfg_wr_data),
      .fields     (fields),
      .win_smm_en (win_smm_en),
      .win_open   (win_open)
   );

   lmd_addr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_SEGS  (NUM_SEGS),
      .SEG_SHIFT (SEG_SHIFT)
   ) u_dec (
      .addr    (acc_addr),
      .region  (region),
      .seg_idx (seg_idx)
   );

   lmd_target_sel #(
      .NUM_FIELDS (NUM_FIELDS),
      .NUM_SEGS   (NUM_SEGS)
   ) u_sel (
      .fields     (fields),
      .region     (region),
      .seg_idx    (seg_idx),
      .smm_active (smm_active),
      .win_smm_en (win_smm_en),
      .win_open   (win_open),
      .tgt        (tgt)
   );

   assign tgt_sel = tgt;
   assign wr_drop = acc_valid && acc_write && (tgt == TGT_RAM_RO);

endmodule

// File: rtl/legacy_mem_decoder_chk.sv
module legacy_mem_decoder_chk #(
   parameter int OFF_W     = 8,
   parameter int ADDR_W    = 32,
   parameter int SMRAM_OFF = 'h72
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic [OFF_W-1:0]  cfg_wr_off,
   input logic [7:0]        cfg_wr_data,
   input logic              smm_active,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        tgt_sel,
   input logic              wr_drop
);
   logic in_low;
   logic in_win;
   logic win_wr;
   logic unused_chk;

   assign in_low     = (acc_addr >> 20) == '0;
   assign in_win     = in_low && (acc_addr[19:17] == 3'b101);
   assign win_wr     = cfg_wr_en && (cfg_wr_off == OFF_W'(SMRAM_OFF));
   assign unused_chk = ^{cfg_wr_data[7], cfg_wr_data[5:4], cfg_wr_data[2:0]};

   AST_TGT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel != 2'd3); // R4

   AST_DROP_ONLY_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |-> (acc_valid && acc_write && tgt_sel == 2'd1)); // R5

   AST_HIGH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_low |-> tgt_sel == 2'd0); // R8

   AST_WIN_OPEN_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(win_wr && cfg_wr_data[6]) && in_win) |-> tgt_sel == 2'd0); // R6

   AST_WIN_SHUT_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(win_wr && !cfg_wr_data[6] && !cfg_wr_data[3]) && in_win) |-> tgt_sel == 2'd2); // R6

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!cfg_wr_en) && $stable(smm_active) && $stable(acc_addr)) |-> $stable(tgt_sel)); // R9

endmodule

bind legacy_mem_decoder legacy_mem_decoder_chk #(
   .OFF_W     (OFF_W),
   .ADDR_W    (ADDR_W),
   .SMRAM_OFF (SMRAM_OFF)
) u_chk (.*);

// File: tb/legacy_mem_decoder_test.sv
`timescale 1ns/1ps
module legacy_mem_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_wr_off = '0;
   logic [7:0]  cfg_wr_data = '0;
   logic        smm_active = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  tgt_sel;
   logic        wr_drop;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [7:0] m_cfg [0:255];

   always #2 clk = ~clk;

   legacy_mem_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_off(cfg_wr_off),
      .cfg_wr_data(cfg_wr_data), .smm_active(smm_active), .acc_valid(acc_valid),
      .acc_write(acc_write), .acc_addr(acc_addr), .tgt_sel(tgt_sel), .wr_drop(wr_drop)
   );

   function automatic logic [1:0] map_attr(input logic [1:0] a);
      if (a == 2'd3) return 2'd0;
      if (a == 2'd1) return 2'd1;
      return 2'd2;
   endfunction

   function automatic logic [1:0] exp_tgt(input logic [31:0] a, input logic smm);
      logic [19:0] lo;
      int          i;
      logic [7:0]  b;
      lo = a[19:0];
      if (a[31:20] != 0) return 2'd0;
      if (lo >= 20'hA0000 && lo < 20'hC0000)
         return ((smm && m_cfg[8'h72][3]) || m_cfg[8'h72][6]) ? 2'd0 : 2'd2;
      if (lo >= 20'hF0000) return map_attr(m_cfg[8'h59][5:4]);
      if (lo >= 20'hC0000) begin
         i = int'((lo - 20'hC0000) >> 14);
         b = m_cfg[8'h5A + i/2];
         return map_attr((i % 2 == 1) ? b[5:4] : b[1:0]);
      end
      return 2'd0;
   endfunction

   task automatic compare(input string req, input logic [1:0] et, input logic ed);
      n_chk++;
      if (tgt_sel !== et || wr_drop !== ed) begin
         n_bad++;
         $display("FAIL %s addr=%h smm=%0b v=%0b w=%0b: tgt=%0d drop=%0b expected tgt=%0d drop=%0b",
                  req, acc_addr, smm_active, acc_valid, acc_write, tgt_sel, wr_drop, et, ed);
      end
   endtask

   task automatic probe(input string req, input logic [31:0] a, input logic w, input logic v);
      logic [1:0] et;
      @(negedge clk);
      acc_addr = a; acc_write = w; acc_valid = v;
      #1;
      et = exp_tgt(a, smm_active);
      compare(req, et, v && w && et == 2'd1);
   endtask

   task automatic cfg_wr(input logic [7:0] off, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_off = off; cfg_wr_data = d;
      @(posedge clk);
      #1;
      cfg_wr_en = 1'b0;
      m_cfg[off] = d;
   endtask

   task automatic set_smm(input logic s);
      @(negedge clk);
      smm_active = s;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] a;
      void'($urandom(32'd4711));
      for (int k = 0; k < 256; k++) m_cfg[k] = 8'h00;
      m_cfg[8'h72] = 8'h02;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state, legacy range goes to PCI even under SMM
      probe("R1", 32'h000F_8000, 1'b0, 1'b1);
      probe("R1", 32'h000C_4000, 1'b1, 1'b1);
      probe("R1", 32'h000A_0000, 1'b0, 1'b1);
      set_smm(1'b1);
      probe("R1", 32'h000B_FFFF, 1'b0, 1'b1);
      set_smm(1'b0);

      // R8: outside the window is RAM
      probe("R8", 32'h0009_FFFF, 1'b1, 1'b1);
      probe("R8", 32'h0010_0000, 1'b0, 1'b1);
      probe("R8", 32'h800F_0000, 1'b1, 1'b1);

      // R9: write takes effect only after its sampling edge
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_off = 8'h59; cfg_wr_data = 8'h30;
      acc_addr = 32'h000F_0000; acc_valid = 1'b1; acc_write = 1'b0;
      #1 compare("R9", 2'd2, 1'b0);
      @(posedge clk);
      #1 cfg_wr_en = 1'b0; m_cfg[8'h59] = 8'h30;
      compare("R9", 2'd0, 1'b0);

      // R2/R4: BIOS segment attributes
      cfg_wr(8'h59, 8'h10);
      probe("R2", 32'h000F_FFFF, 1'b0, 1'b1);
      probe("R5", 32'h000F_1234, 1'b1, 1'b1);
      probe("R5", 32'h000F_1234, 1'b1, 1'b0);
      cfg_wr(8'h59, 8'h23);
      probe("R4", 32'h000F_0000, 1'b1, 1'b1);
      // R10: low field of 0x59 and ignored bits
      cfg_wr(8'h59, 8'hCF);
      probe("R10", 32'h000F_0000, 1'b0, 1'b1);

      // R3: each segment individually, boundaries
      for (int s = 0; s < 12; s++) begin
         for (int k = 8'h5A; k <= 8'h5F; k++) cfg_wr(8'(k), 8'h00);
         cfg_wr(8'(8'h5A + s/2), (s % 2 == 1) ? 8'h30 : 8'h03);
         probe("R3", 32'h000C_0000 + 32'(s) * 32'h4000, 1'b1, 1'b1);
         probe("R3", 32'h000C_3FFF + 32'(s) * 32'h4000, 1'b0, 1'b1);
         if (s < 11) probe("R3", 32'h000C_4000 + 32'(s) * 32'h4000, 1'b0, 1'b1);
      end
      cfg_wr(8'h5A, 8'hCC);
      probe("R10", 32'h000C_0000, 1'b1, 1'b1);
      probe("R10", 32'h000C_4000, 1'b1, 1'b1);

      // R6/R7: window conditions, same-cycle SMM response
      cfg_wr(8'h72, 8'h08);
      probe("R6", 32'h000A_8000, 1'b0, 1'b1);
      @(negedge clk);
      smm_active = 1'b1; acc_addr = 32'h000A_8000;
      #1 compare("R7", 2'd0, 1'b0);
      @(negedge clk);
      smm_active = 1'b0;
      #1 compare("R7", 2'd2, 1'b0);
      cfg_wr(8'h72, 8'h40);
      probe("R6", 32'h000B_0000, 1'b1, 1'b1);
      cfg_wr(8'h72, 8'hB7);
      set_smm(1'b1);
      probe("R6", 32'h000A_0000, 1'b0, 1'b1);
      set_smm(1'b0);

      // R9: neighbouring offsets are ignored
      cfg_wr(8'h59, 8'h30);
      cfg_wr(8'h72, 8'h00);
      cfg_wr(8'h58, 8'hFF);
      cfg_wr(8'h60, 8'hFF);
      cfg_wr(8'h71, 8'hFF);
      cfg_wr(8'h73, 8'hFF);
      probe("R9", 32'h000F_0000, 1'b1, 1'b1);
      probe("R9", 32'h000A_0000, 1'b1, 1'b1);
      probe("R9", 32'h000E_C000, 1'b1, 1'b1);

      // Random mix
      for (int n = 0; n < 1500; n++) begin
         int r;
         r = int'($urandom_range(0, 9));
         if (r < 2) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 7)       cfg_wr(8'(8'h59 + sel), 8'($urandom));
            else if (sel == 7) cfg_wr(8'h72, 8'($urandom));
            else               cfg_wr(8'($urandom), 8'($urandom));
         end else if (r == 2) begin
            set_smm(1'($urandom));
         end else begin
            a = 32'h000A_0000 + 32'($urandom_range(0, 32'h5FFFF));
            if ($urandom_range(0, 9) == 0) a = $urandom;
            probe("R5", a, 1'($urandom), 1'($urandom));
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule